// File: doc/BRIEF.md
# Coprocessor Mailbox Command Sequencer

This block is a host-side bus master that hands one command to an embedded coprocessor and collects its answer. The coprocessor shares a small message RAM and two mailbox registers with the host. A request carries a command index and two argument words. The sequencer writes a five-word message into the message RAM: a header, the command, the two arguments and a checksum. It then rings the doorbell by writing 1 to the to-coprocessor mailbox.

After the doorbell, the block keeps reading the to-host mailbox until the value is nonzero. The number of reads has an upper bound. Once an answer arrives, the block reads the five reply words back, writes 0 to the to-host mailbox to release it, and checks the reply checksum. It then reports a 32-bit status word. It also splits the first reply argument into a region tag and an offset, so that the caller knows where the coprocessor left its data. The returned data itself is not fetched here.

The register bus is a single-beat request/acknowledge port. The block holds each request stable until it is acknowledged, and it drives the bus only while a command is in flight.

Top module: `mbox_cmd_seq`

## Requirements
- R1: After reset, `busy`, `done` and `bus_req` are 0 and `status` reads 0.
- R2: An accepted command writes five words, in order, to byte addresses 0x100, 0x104, 0x108, 0x10C and 0x110. The words are: header 1, the command index zero-extended, argument 0, argument 1, and the 32-bit wrapping sum of those four words.
- R3: Right after the fifth message word, the block writes the value 1 to address 0x10 (to-coprocessor mailbox).
- R4: The block then reads address 0x14 (to-host mailbox) repeatedly until a read returns nonzero. That nonzero value is the reported status, unless R7 applies.
- R5: If POLL_MAX reads of 0x14 all return 0, the block stops polling and skips the message readback. It still writes 0 to 0x14, and it reports status 0x00000010.
- R6: When a nonzero mailbox value arrives, the block reads the five words at 0x100..0x110 in order. It then writes 0 to 0x14 before reporting.
- R7: If the sum of reply words 0..3 (modulo 2^32) differs from reply word 4, the status becomes 0x80000004, whatever the mailbox held.
- R8: Reply word 2 is split as follows. Bits 31:28 give the type and bits 27:0 go to `ptr_offset`. Type 1 sets `ptr_msg_ram` (offset is relative to the message RAM). Type 0 clears both `ptr_msg_ram` and `ptr_fatal` (offset is relative to the data RAM). Any other type sets `ptr_fatal`.
- R9: A request whose command index is NUM_CMDS or more is rejected with status 0x80000002. `done` pulses in the cycle after the request, `busy` stays low and no bus access is made.
- R10: `busy` is high from the cycle after a valid request until `done`. `done` is a one-cycle pulse with `busy` low. A request presented while `busy` is high is ignored.
- R11: `bus_req` is high only while `busy` is high. Address, write enable and write data stay unchanged until `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command request strobe, taken when idle |
| req_cmd | input | CMD_W | Command index |
| req_arg0 | input | 32 | First argument word |
| req_arg1 | input | 32 | Second argument word |
| busy | output | 1 | Command in flight |
| done | output | 1 | One-cycle pulse: status and pointer fields valid |
| status | output | 32 | Result code |
| ptr_msg_ram | output | 1 | Reply pointer refers to the message RAM |
| ptr_fatal | output | 1 | Reply pointer type is not recognised |
| ptr_offset | output | 28 | Reply pointer offset |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Bus access is a write |
| bus_addr | output | ADDR_W | Byte address of the access |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access completed this cycle |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |

## Verification
A modelled coprocessor on the bus answers commands in several ways:
- immediately, or after a number of empty polls;
- with the success code, with an error code, or never;
- with a correct or a corrupted reply checksum;
- with each of the three kinds of pointer tag.

Every bus access is logged, so the exact order of writes, polls, readback and release is compared against the expected sequence. This shows the doorbell, timeout and acknowledge paths apart from one another. Argument words that overflow the checksum sum check the wrapping, and an acknowledge delayed by several cycles checks that requests are held. An out-of-range command and a request made during a transaction check rejection and the single-outstanding rule.

// File: rtl/mbox_cmd_seq.sv
module mbox_cmd_seq #(
  parameter int ADDR_W   = 12,
  parameter int CMD_W    = 4,
  parameter int NUM_CMDS = 3,
  parameter int POLL_MAX = 200000,
  parameter logic [ADDR_W-1:0] MSG_BASE     = 'h100,
  parameter logic [ADDR_W-1:0] TO_COP_ADDR  = 'h010,
  parameter logic [ADDR_W-1:0] TO_HOST_ADDR = 'h014
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic [31:0]       req_arg0,
  input  logic [31:0]       req_arg1,
  output logic              busy,
  output logic              done,
  output logic [31:0]       status,
  output logic              ptr_msg_ram,
  output logic              ptr_fatal,
  output logic [27:0]       ptr_offset,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [31:0]       bus_rdata
);

  localparam int N_WORDS = 5;
  localparam int PC_W    = $clog2(POLL_MAX + 1);
  localparam logic [CMD_W-1:0] CMD_LIM  = CMD_W'(NUM_CMDS);
  localparam logic [PC_W-1:0]  POLL_END = PC_W'(POLL_MAX - 1);
  localparam logic [31:0] HDR_CMD     = 32'h0000_0001;
  localparam logic [31:0] ST_INVAL    = 32'h8000_0002;
  localparam logic [31:0] ST_BAD_SUM  = 32'h8000_0004;
  localparam logic [31:0] ST_TIMEOUT  = 32'h0000_0010;

  typedef enum logic [2:0] {S_IDLE, S_WMSG, S_DOOR, S_POLL, S_RMSG, S_ACK} state_t;

  state_t          state;
  logic [2:0]      idx;
  logic [PC_W-1:0] polls;
  logic [31:0]     cmd_w, a0, a1, mbox_val;
  logic [31:0]     rx [N_WORDS];
  logic            timed_out;
  logic [31:0]     tx_word;

  wire xfer      = bus_req & bus_ack;
  wire last_word = (idx == 3'(N_WORDS - 1));
  wire [31:0] tx_sum = HDR_CMD + cmd_w + a0 + a1;
  wire [31:0] rx_sum = rx[0] + rx[1] + rx[2] + rx[3];
  wire [3:0]  ptr_type = rx[2][31:28];

  assign busy    = (state != S_IDLE);
  assign bus_req = busy;
  assign bus_we  = (state == S_WMSG) || (state == S_DOOR) || (state == S_ACK);

  always_comb begin
    case (idx)
      3'd0:    tx_word = HDR_CMD;
      3'd1:    tx_word = cmd_w;
      3'd2:    tx_word = a0;
      3'd3:    tx_word = a1;
      default: tx_word = tx_sum;
    endcase
  end

  always_comb begin
    case (state)
      S_WMSG, S_RMSG: bus_addr = MSG_BASE + ADDR_W'({idx, 2'b00});
      S_DOOR:         bus_addr = TO_COP_ADDR;
      default:        bus_addr = TO_HOST_ADDR;
    endcase
  end

  assign bus_wdata = (state == S_WMSG) ? tx_word :
                     (state == S_DOOR) ? 32'd1 : 32'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      idx         <= '0;
      polls       <= '0;
      cmd_w       <= '0;
      a0          <= '0;
      a1          <= '0;
      mbox_val    <= '0;
      timed_out   <= 1'b0;
      done        <= 1'b0;
      status      <= '0;
      ptr_msg_ram <= 1'b0;
      ptr_fatal   <= 1'b0;
      ptr_offset  <= '0;
      for (int i = 0; i < N_WORDS; i++) rx[i] <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          if (req_cmd >= CMD_LIM) begin
            done        <= 1'b1;
            status      <= ST_INVAL;
            ptr_msg_ram <= 1'b0;
            ptr_fatal   <= 1'b0;
            ptr_offset  <= '0;
          end else begin
            state     <= S_WMSG;
            idx       <= '0;
            polls     <= '0;
            cmd_w     <= 32'(req_cmd);
            a0        <= req_arg0;
            a1        <= req_arg1;
            mbox_val  <= '0;
            timed_out <= 1'b0;
            for (int i = 0; i < N_WORDS; i++) rx[i] <= '0;
          end
        end
        S_WMSG: if (xfer) begin
          if (last_word) begin
            idx   <= '0;
            state <= S_DOOR;
          end else idx <= idx + 3'd1;
        end
        S_DOOR: if (xfer) state <= S_POLL;
        S_POLL: if (xfer) begin
          if (bus_rdata != 32'd0) begin
            mbox_val <= bus_rdata;
            idx      <= '0;
            state    <= S_RMSG;
          end else if (polls == POLL_END) begin
            timed_out <= 1'b1;
            state     <= S_ACK;
          end else polls <= polls + 1'b1;
        end
        S_RMSG: if (xfer) begin
          rx[idx] <= bus_rdata;
          if (last_word) state <= S_ACK;
          else idx <= idx + 3'd1;
        end
        S_ACK: if (xfer) begin
          state       <= S_IDLE;
          done        <= 1'b1;
          status      <= timed_out ? ST_TIMEOUT :
                         (rx_sum != rx[4]) ? ST_BAD_SUM : mbox_val;
          ptr_msg_ram <= (ptr_type == 4'd1);
          ptr_fatal   <= (ptr_type > 4'd1);
          ptr_offset  <= rx[2][27:0];
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);  // R10

  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);  // R10

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));  // R11

  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_POLL) |-> (polls < PC_W'(POLL_MAX)));  // R5

  AST_INVAL_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_cmd >= CMD_LIM) |=> (!bus_req && done && status == ST_INVAL));  // R9

endmodule

// File: tb/tb_mbox_cmd_seq.sv
module tb_mbox_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int CMD_W = 4;
  localparam int PMAX = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [CMD_W-1:0] req_cmd = '0;
  logic [31:0] req_arg0 = '0, req_arg1 = '0;
  logic busy, done, ptr_msg_ram, ptr_fatal;
  logic [31:0] status;
  logic [27:0] ptr_offset;
  logic bus_req, bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0] bus_wdata;
  logic bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_cmd_seq #(.ADDR_W(ADDR_W), .CMD_W(CMD_W), .NUM_CMDS(3), .POLL_MAX(PMAX)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_arg0(req_arg0), .req_arg1(req_arg1), .busy(busy), .done(done),
    .status(status), .ptr_msg_ram(ptr_msg_ram), .ptr_fatal(ptr_fatal),
    .ptr_offset(ptr_offset), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata));

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  // coprocessor model
  logic [31:0] cop_msg [5];
  logic [31:0] to_host;
  bit pend;
  int left, n_acc, viol;
  int dly_cfg, lat_cfg;
  logic [31:0] code_cfg, ptr_cfg;
  bit bad_cfg;
  logic [ADDR_W-1:0] tr_addr [64];
  logic tr_we [64];
  logic [31:0] tr_wd [64];
  bit waiting;
  int wcnt;
  logic [ADDR_W-1:0] w_addr;
  logic [31:0] w_wd;
  logic w_we;

  task automatic model_reset(input logic [31:0] code, input logic [31:0] ptr,
                             input int dly, input bit bad, input int lat);
    for (int i = 0; i < 5; i++) cop_msg[i] = '0;
    to_host = '0; pend = 0; left = 0; n_acc = 0; viol = 0;
    code_cfg = code; ptr_cfg = ptr; dly_cfg = dly; bad_cfg = bad; lat_cfg = lat;
  endtask

  task automatic serve;
    int k;
    k = (int'(bus_addr) - 'h100) >> 2;
    if (n_acc < 64) begin
      tr_addr[n_acc] = bus_addr; tr_we[n_acc] = bus_we; tr_wd[n_acc] = bus_wdata;
    end
    n_acc++;
    bus_rdata = '0;
    if (bus_we) begin
      if (bus_addr >= 'h100 && bus_addr <= 'h110) cop_msg[k] = bus_wdata;
      else if (bus_addr == 'h010) begin
        if (bus_wdata == 32'd1) begin pend = 1; left = dly_cfg; end
      end else if (bus_addr == 'h014) to_host = bus_wdata;
    end else begin
      if (bus_addr == 'h014) begin
        if (pend && to_host == 0) begin
          if (left == 0) begin
            cop_msg[0] = 32'd2;
            cop_msg[2] = ptr_cfg;
            cop_msg[3] = cop_msg[3] ^ 32'h5A5A_0000;
            cop_msg[4] = cop_msg[0] + cop_msg[1] + cop_msg[2] + cop_msg[3] + (bad_cfg ? 32'd1 : 32'd0);
            to_host = code_cfg;
            pend = 0;
          end else left--;
        end
        bus_rdata = to_host;
      end else if (bus_addr >= 'h100 && bus_addr <= 'h110) bus_rdata = cop_msg[k];
    end
  endtask

  initial begin
    waiting = 0; wcnt = 0;
    model_reset(32'd1, 32'd0, 0, 0, 0);
    forever begin
      @(negedge clk);
      if (bus_req && !busy) viol++;
      if (bus_ack) bus_ack = 1'b0;
      else if (bus_req) begin
        if (!waiting) begin
          waiting = 1; wcnt = lat_cfg; w_addr = bus_addr; w_wd = bus_wdata; w_we = bus_we;
        end else if (bus_addr != w_addr || bus_wdata != w_wd || bus_we != w_we) viol++;
        if (wcnt == 0) begin
          serve; bus_ack = 1'b1; waiting = 0;
        end else wcnt--;
      end
    end
  end

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [3:0] cmd, input logic [31:0] x0, input logic [31:0] x1,
                         output int cycles, output logic busy_seen);
    @(negedge clk);
    req_valid = 1'b1; req_cmd = cmd; req_arg0 = x0; req_arg1 = x1;
    @(negedge clk);
    req_valid = 1'b0;
    busy_seen = busy;
    cycles = 1;
    while (!done && cycles < 2000) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic check_trace(input string tag, input logic [3:0] cmd, input logic [31:0] x0,
                             input logic [31:0] x1, input int npolls, input bit readback);
    logic [ADDR_W-1:0] ea [64];
    logic ew [64];
    logic [31:0] ed [64];
    int n;
    bit ok;
    logic [31:0] w [5];
    w[0] = 32'd1; w[1] = 32'(cmd); w[2] = x0; w[3] = x1;
    w[4] = w[0] + w[1] + w[2] + w[3];
    n = 0;
    for (int i = 0; i < 5; i++) begin ea[n] = ADDR_W'('h100 + 4*i); ew[n] = 1; ed[n] = w[i]; n++; end
    ea[n] = 'h010; ew[n] = 1; ed[n] = 32'd1; n++;
    for (int i = 0; i < npolls; i++) begin ea[n] = 'h014; ew[n] = 0; ed[n] = 'x; n++; end
    if (readback) for (int i = 0; i < 5; i++) begin ea[n] = ADDR_W'('h100 + 4*i); ew[n] = 0; ed[n] = 'x; n++; end
    ea[n] = 'h014; ew[n] = 1; ed[n] = 32'd0; n++;
    ok = (n_acc == n);
    check32({tag, " access count"}, 32'(n_acc), 32'(n));
    if (ok) begin
      for (int i = 0; i < n; i++) begin
        if (tr_addr[i] !== ea[i] || tr_we[i] !== ew[i] || (ew[i] && tr_wd[i] !== ed[i])) begin
          if (ok) $display("FAIL %s: access %0d actual addr %h we %b data %h expected addr %h we %b data %h",
                           tag, i, tr_addr[i], tr_we[i], tr_wd[i], ea[i], ew[i], ed[i]);
          ok = 0;
        end
      end
      n_checks++;
      if (!ok) n_fail++;
    end
  endtask

  task automatic t_reset;
    check32("R1 busy", 32'(busy), 0);
    check32("R1 done", 32'(done), 0);
    check32("R1 bus_req", 32'(bus_req), 0);
    check32("R1 status", status, 0);
  endtask

  task automatic t_basic;
    int c; logic b;
    model_reset(32'd1, 32'h1000_0123, 0, 0, 0);
    run_cmd(4'd0, 32'h1111_2222, 32'h3333_4444, c, b);
    check32("R10 busy after accept", 32'(b), 1);
    check32("R4 status success", status, 32'd1);
    check32("R8 msg ram tag", {30'd0, ptr_fatal, ptr_msg_ram}, 32'd1);
    check32("R8 offset", 32'(ptr_offset), 32'h123);
    check_trace("R2 R3 R6 basic", 4'd0, 32'h1111_2222, 32'h3333_4444, 1, 1);
    @(negedge clk);
    check32("R10 done one cycle", 32'(done), 0);
  endtask

  task automatic t_delayed;
    int c; logic b;
    model_reset(32'd1, 32'h0ABC_DEF0, 5, 0, 0);
    run_cmd(4'd2, 32'hDEAD_BEEF, 32'h0000_0007, c, b);
    check32("R4 delayed status", status, 32'd1);
    check32("R8 data ram tag", {30'd0, ptr_fatal, ptr_msg_ram}, 32'd0);
    check32("R8 data offset", 32'(ptr_offset), 32'h0ABC_DEF0);
    check_trace("R4 six polls", 4'd2, 32'hDEAD_BEEF, 32'h0000_0007, 6, 1);
  endtask

  task automatic t_err_code;
    int c; logic b;
    model_reset(32'h8000_0008, 32'h1000_0000, 2, 0, 0);
    run_cmd(4'd1, 32'h0, 32'h0, c, b);
    check32("R4 error code passed", status, 32'h8000_0008);
  endtask

  task automatic t_bad_sum;
    int c; logic b;
    model_reset(32'd1, 32'h1000_0040, 1, 1, 0);
    run_cmd(4'd1, 32'h5, 32'h6, c, b);
    check32("R7 checksum error", status, 32'h8000_0004);
  endtask

  task automatic t_fatal_tag;
    int c; logic b;
    model_reset(32'd1, 32'h5000_0010, 0, 0, 0);
    run_cmd(4'd0, 32'h1, 32'h2, c, b);
    check32("R8 fatal tag", {30'd0, ptr_fatal, ptr_msg_ram}, 32'd2);
  endtask

  task automatic t_wrap;
    int c; logic b;
    model_reset(32'd1, 32'h1000_0000, 0, 0, 0);
    run_cmd(4'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFE, c, b);
    check32("R2 wrap status", status, 32'd1);
    check32("R2 wrap checksum word", tr_wd[4], 32'h0000_0000);
    check_trace("R2 wrap", 4'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 1, 1);
  endtask

  task automatic t_timeout;
    int c; logic b;
    model_reset(32'd1, 32'h1000_0000, 1000, 0, 0);
    run_cmd(4'd1, 32'hA, 32'hB, c, b);
    check32("R5 timeout status", status, 32'h0000_0010);
    check_trace("R5 timeout", 4'd1, 32'hA, 32'hB, PMAX, 0);
  endtask

  task automatic t_invalid;
    int c; logic b;
    model_reset(32'd1, 32'h1000_0000, 0, 0, 0);
    run_cmd(4'd3, 32'h1, 32'h1, c, b);
    check32("R9 busy stays low", 32'(b), 0);
    check32("R9 done next cycle", 32'(done), 1);
    check32("R9 reject code", status, 32'h8000_0002);
    check32("R9 no bus access", 32'(n_acc), 0);
  endtask

  task automatic t_busy_ignore;
    int c;
    model_reset(32'd1, 32'h1000_0000, 3, 0, 0);
    @(negedge clk);
    req_valid = 1'b1; req_cmd = 4'd1; req_arg0 = 32'h77; req_arg1 = 32'h88;
    @(negedge clk);
    req_cmd = 4'd5;
    @(negedge clk);
    req_valid = 1'b0;
    c = 0;
    while (!done && c < 2000) begin @(negedge clk); c++; end
    check32("R10 second request ignored", status, 32'd1);
    check_trace("R10 single transaction", 4'd1, 32'h77, 32'h88, 4, 1);
  endtask

  task automatic t_stall;
    int c; logic b;
    model_reset(32'd1, 32'h1000_0008, 1, 0, 3);
    run_cmd(4'd0, 32'h9, 32'hA, c, b);
    check32("R11 stalled status", status, 32'd1);
    check32("R11 bus held and only while busy", 32'(viol), 0);
    check_trace("R11 stalled", 4'd0, 32'h9, 32'hA, 2, 1);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    summary;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_basic;
    t_delayed;
    t_err_code;
    t_bad_sum;
    t_fatal_tag;
    t_wrap;
    t_timeout;
    t_invalid;
    t_busy_ignore;
    t_stall;
    check32("R11 no stray requests", 32'(viol), 0);
    repeat (3) @(negedge clk);
    summary;
  end
endmodule